// File: doc/BRIEF.md
# Modem Status Change Detector

This block watches four active-low modem handshake inputs (clear-to-send, data-set-ready, ring indicator, carrier detect). It presents them to software as one 8-bit status byte. The upper nibble shows the present level of each line, active-high. The lower nibble holds sticky change flags, so software can see that a line moved since the last time it read the byte.

Reading the byte clears the flags. A flag that is set raises an interrupt request when interrupts are enabled, except that clear-to-send changes are kept out of the interrupt while automatic transmit gating by clear-to-send is on.

A loopback mode replaces the pins with four modem-control output values. This lets the change logic be exercised without external wiring. Each pin passes through a two-stage synchronizer before its edges are detected.

Top module: `modem_status_tracker`

## Requirements
- R1: Status bit 0 (clear-to-send), bit 1 (data-set-ready) and bit 3 (carrier detect) each set when that line's level changes in either direction since the last read.
- R2: Status bit 2 sets only when the ring indicator becomes inactive (pin goes low to high). Its activation (pin high to low) leaves bit 2 unchanged.
- R3: Status bits 4, 5, 6 and 7 show the active-high level of clear-to-send, data-set-ready, ring indicator and carrier detect. A pin change appears on the third rising clock edge after it, together with its flag.
- R4: When `rd_stb` is high at a rising edge, flags set before that edge are cleared. The value presented during the read cycle is the pre-clear value.
- R5: A change detected on the same edge as a read leaves its flag set after the read.
- R6: `irq` is high exactly when `irq_en` is high and any flag among bits 3..0 is set.
- R7: While `auto_cts_en` is high, status bit 0 does not contribute to `irq`, but bit 0 still records the change.
- R8: Reset clears all four flags and `irq`, and shows all four levels inactive (status reads 0x00 with the pins inactive).
- R9: With `loop_en` high, the levels come from `lb_rts`→clear-to-send, `lb_dtr`→data-set-ready, `lb_out1`→ring indicator and `lb_out2`→carrier detect, active-high, one edge after they change. Pin activity is then ignored.
- R10: A flag stays set over any number of cycles without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous master reset, active high |
| cts_n | input | 1 | Clear-to-send pin, active low |
| dsr_n | input | 1 | Data-set-ready pin, active low |
| ri_n | input | 1 | Ring indicator pin, active low |
| dcd_n | input | 1 | Carrier detect pin, active low |
| loop_en | input | 1 | Loopback select |
| lb_rts | input | 1 | Loopback source for clear-to-send |
| lb_dtr | input | 1 | Loopback source for data-set-ready |
| lb_out1 | input | 1 | Loopback source for ring indicator |
| lb_out2 | input | 1 | Loopback source for carrier detect |
| auto_cts_en | input | 1 | Excludes clear-to-send changes from the interrupt |
| irq_en | input | 1 | Modem-status interrupt enable |
| rd_stb | input | 1 | One-cycle read strobe of the status byte |
| status | output | 8 | Status byte: levels in bits 7..4, flags in bits 3..0 |
| irq | output | 1 | Modem-status interrupt request |

## Verification
The hardest case to reach is a line change that lands on exactly the edge where software reads and clears the byte. Through the pins, the synchronizer latency makes that timing awkward to hit. The bench therefore uses loopback, where a level change counts one edge later. It raises the loopback source and the read strobe in the same cycle, then confirms the flag survives the clear. It also reads once more to confirm the flag then clears.

// File: rtl/modem_status_tracker.sv
module modem_status_tracker #(
  parameter int SYNC_STAGES = 2,
  localparam int LINES = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cts_n,
  input  logic       dsr_n,
  input  logic       ri_n,
  input  logic       dcd_n,
  input  logic       loop_en,
  input  logic       lb_rts,
  input  logic       lb_dtr,
  input  logic       lb_out1,
  input  logic       lb_out2,
  input  logic       auto_cts_en,
  input  logic       irq_en,
  input  logic       rd_stb,
  output logic [7:0] status,
  output logic       irq
);

  logic [LINES-1:0] sync_q [SYNC_STAGES];
  logic [LINES-1:0] pin_act, lb_act, lvl, lvl_q, chg, flags;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '1;
    end else begin
      sync_q[0] <= {dcd_n, ri_n, dsr_n, cts_n};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign pin_act = ~sync_q[SYNC_STAGES-1];
  assign lb_act  = {lb_out2, lb_out1, lb_dtr, lb_rts};
  assign lvl     = loop_en ? lb_act : pin_act;

  assign chg = {lvl[3] ^ lvl_q[3],
                lvl_q[2] & ~lvl[2],
                lvl[1] ^ lvl_q[1],
                lvl[0] ^ lvl_q[0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= '0;
      flags <= '0;
    end else begin
      lvl_q <= lvl;
      flags <= (flags & {LINES{~rd_stb}}) | chg;
    end
  end

  assign status = {lvl_q, flags};
  assign irq    = irq_en & (|(flags & {3'b111, ~auto_cts_en}));

endmodule

module modem_status_tracker_chk (
  input logic       clk,
  input logic       rst,
  input logic       rd_stb,
  input logic       irq_en,
  input logic       auto_cts_en,
  input logic [7:0] status,
  input logic       irq
);

  // R1, R4
  a_r4_cts_after_read: assert property (@(posedge clk) disable iff (rst)
    rd_stb |=> status[0] == (status[4] != $past(status[4])));

  // R1, R4
  a_r4_dcd_after_read: assert property (@(posedge clk) disable iff (rst)
    rd_stb |=> status[3] == (status[7] != $past(status[7])));

  // R2
  a_r2_ri_trailing: assert property (@(posedge clk) disable iff (rst)
    rd_stb |=> status[2] == ($past(status[6]) && !status[6]));

  // R10
  a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
    (!rd_stb && status[1]) |=> status[1]);

  // R6
  a_r6_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
    irq |-> irq_en);

  // R6
  a_r6_irq_on_flag: assert property (@(posedge clk) disable iff (rst)
    (irq_en && status[3:1] != 3'b000) |-> irq);

  // R7
  a_r7_cts_masked: assert property (@(posedge clk) disable iff (rst)
    (auto_cts_en && status[3:1] == 3'b000) |-> !irq);

  // R8
  a_r8_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> (status[3:0] == 4'b0000 && !irq));

endmodule

bind modem_status_tracker modem_status_tracker_chk u_chk (.*);

// File: tb/modem_status_tracker_tb.sv
module modem_status_tracker_tb;
  logic clk = 0, rst = 1;
  logic cts_n = 1, dsr_n = 1, ri_n = 1, dcd_n = 1;
  logic loop_en = 0, lb_rts = 0, lb_dtr = 0, lb_out1 = 0, lb_out2 = 0;
  logic auto_cts_en = 0, irq_en = 0, rd_stb = 0;
  logic [7:0] status;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  modem_status_tracker u_dut (.*);

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_read(output logic [7:0] v);
    v = status;
    rd_stb = 1;
    step(1);
    rd_stb = 0;
  endtask

  task automatic t_reset;
    rst = 1;
    step(3);
    rst = 0;
    step(1);
    chk("R8 reset status", status, 8'h00);
    chk("R8 reset irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_pins;
    logic [7:0] v;
    cts_n = 0;
    step(2);
    chk("R3 latency not yet", status, 8'h00);
    step(1);
    chk("R1 R3 cts active", status, 8'h11);
    do_read(v);
    chk("R4 read value", v, 8'h11);
    chk("R4 cleared", status, 8'h10);
    dsr_n = 0; dcd_n = 0;
    step(3);
    chk("R1 dsr dcd active", status, 8'hBA);
    do_read(v);
    cts_n = 1; dsr_n = 1; dcd_n = 1;
    step(3);
    chk("R1 all inactive", status, 8'h0B);
    step(20);
    chk("R10 sticky", status, 8'h0B);
    do_read(v);
    chk("R4 cleared again", status, 8'h00);
  endtask

  task automatic t_ri;
    logic [7:0] v;
    ri_n = 0;
    step(3);
    chk("R2 ri leading no flag", status, 8'h40);
    ri_n = 1;
    step(3);
    chk("R2 ri trailing flag", status, 8'h04);
    do_read(v);
    chk("R2 ri cleared", status, 8'h00);
  endtask

  task automatic t_irq;
    logic [7:0] v;
    irq_en = 0;
    dsr_n = 0;
    step(3);
    chk("R6 irq off when disabled", {7'd0, irq}, 8'h00);
    irq_en = 1;
    step(1);
    chk("R6 irq on", {7'd0, irq}, 8'h01);
    do_read(v);
    chk("R6 irq drops after read", {7'd0, irq}, 8'h00);
    dsr_n = 1;
    step(3);
    do_read(v);
    auto_cts_en = 1;
    cts_n = 0;
    step(3);
    chk("R7 cts flag still recorded", status, 8'h11);
    chk("R7 cts masked", {7'd0, irq}, 8'h00);
    auto_cts_en = 0;
    step(1);
    chk("R7 cts unmasked", {7'd0, irq}, 8'h01);
    do_read(v);
    cts_n = 1;
    step(3);
    do_read(v);
    irq_en = 0;
    chk("R6 clean", status, 8'h00);
  endtask

  task automatic t_loop;
    logic [7:0] v;
    loop_en = 1;
    step(1);
    chk("R9 enter loop quiet", status, 8'h00);
    lb_rts = 1;
    step(1);
    chk("R9 rts to cts", status, 8'h11);
    do_read(v);
    cts_n = 0; dsr_n = 0; ri_n = 0; dcd_n = 0;
    step(4);
    chk("R9 pins ignored", status, 8'h10);
    cts_n = 1; dsr_n = 1; ri_n = 1; dcd_n = 1;
    lb_dtr = 1; rd_stb = 1;
    step(1);
    rd_stb = 0;
    chk("R5 coincident change kept", status, 8'h32);
    do_read(v);
    chk("R5 cleared afterwards", status, 8'h30);
    lb_out1 = 1; lb_out2 = 1;
    step(1);
    chk("R9 out1 out2 map", status, 8'hF8);
    lb_out1 = 0;
    step(1);
    chk("R9 R2 loop ri trailing", status, 8'hBC);
    lb_rts = 0; lb_dtr = 0; lb_out2 = 0;
    step(1);
    do_read(v);
    loop_en = 0;
    step(4);
    chk("R9 leave loop", status, 8'h00);
  endtask

  initial begin
    t_reset();
    t_pins();
    t_ri();
    t_irq();
    t_loop();
    t_reset();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule